// File: doc/BRIEF.md
# Link Test Pattern Generator with Preamble

This block produces one parallel transmit word per clock for exercising a serial link. After a start command it can first send a programmable preamble word for a programmable number of beats, and then a continuous test stream. The stream is one of seven sources: four pseudo-random binary sequences of different lengths, a low-frequency square wave, a high-frequency toggle pattern, or user data passed through unchanged in bypass mode. A one-cycle inject command flips a single bit of the outgoing pattern so that a far-end checker can be shown to detect errors.

The block is a library component. The word width and the width of the preamble beat counter are parameters. The outputs are registered, so every command takes effect on the word that appears one clock after the edge at which the command is sampled. Inside the block a three-state controller (idle, preamble, pattern) drives a bank of LFSR word generators and a fixed-pattern generator. All of these generators run side by side, so the pattern select may change while the block is running.

Top module: `linktest_patgen`

## Requirements
- R1: After reset, and whenever the block is idle, `dout` is all zeros and `dout_valid` is low.
- R2: A `start` sampled while `pre_en` is high and `pre_beats` is N > 0 yields exactly N words equal to `pre_word` with `dout_valid` high, beginning one cycle after the start edge, and the pattern follows in the next cycle. With `pre_en` low or N = 0, the first pattern word appears one cycle after the start edge.
- R3: `pat_sel` codes 0, 1, 2 and 3 select PRBS of order 7, 15, 23 and 31, with feedback taps at stages 6, 14, 18 and 28. Each LFSR is reseeded to all ones on start. For each bit, the new bit is stage[order] XOR stage[tap]; that bit is emitted and shifted into the low end. Bit 0 of a word is the earliest bit. All four LFSRs advance by one word in every pattern cycle.
- R4: `pat_sel` code 4 gives a low-frequency wave. The bit at stream position p, counted from 0 at start with bit 0 of each word first, is 1 when p mod 10 < 5.
- R5: `pat_sel` code 5 gives a high-frequency toggle. The bit at stream position p is 1 when p is even.
- R6: `pat_sel` codes 6 and 7 select bypass. Each pattern word equals the `user_data` sampled at the same edge.
- R7: An `inject_err` pulse sampled during the pattern state, with neither `start` nor `stop` high, inverts bit 0 of the next pattern word only.
- R8: `inject_err` has no effect while idle, during the preamble (including its last beat), or in a cycle where `start` or `stop` is also high.
- R9: A sampled `stop` returns the block to idle, so the next word is zero and not valid. `stop` overrides a `start` in the same cycle.
- R10: A `start` sampled while the block is running restarts the whole sequence: the LFSRs are reseeded, the pattern phases return to zero, and the preamble is sent again if it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start or restart the sequence |
| stop | input | 1 | Halt and return to idle |
| pat_sel | input | 3 | Pattern source select (codes per R3 to R6) |
| pre_en | input | 1 | Send the preamble before the pattern |
| pre_word | input | W | Preamble word |
| pre_beats | input | BEAT_W | Number of preamble beats |
| inject_err | input | 1 | Single-bit error injection pulse |
| user_data | input | W | Data used in bypass mode |
| dout | output | W | Registered transmit word |
| dout_valid | output | 1 | High while the preamble or the pattern is sent |

## Verification
The commands that can meet in one cycle are error injection and start/stop. The bench raises `inject_err` on the same edge as a restarting `start`, on the same edge as `stop`, and on the last preamble beat where the controller enters the pattern state. In each case it expects an unflipped fresh-seed word, an idle zero word, or an unflipped first pattern word. It also applies `start` and `stop` together while idle and expects the block to stay silent.

// File: rtl/ltpg_pkg.sv
package ltpg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_PATT = 2'd2
   } ltpg_state_e;

   typedef enum logic [1:0] {
      EM_NONE = 2'd0,
      EM_PRE  = 2'd1,
      EM_PATT = 2'd2
   } ltpg_emit_e;

   localparam int          NUM_PRBS = 4;
   localparam logic [2:0]  SEL_LOW  = 3'd4;
   localparam logic [2:0]  SEL_HIGH = 3'd5;

   function automatic int prbs_order(input int k);
      case (k)
         0:       return 7;
         1:       return 15;
         2:       return 23;
         default: return 31;
      endcase
   endfunction

   function automatic int prbs_tap(input int k);
      case (k)
         0:       return 6;
         1:       return 14;
         2:       return 18;
         default: return 28;
      endcase
   endfunction

endpackage

// File: rtl/ltpg_prbs_word.sv
module ltpg_prbs_word #(
   parameter int W     = 32,
   parameter int ORDER = 7,
   parameter int TAP   = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         advance,
   output logic [W-1:0] word
);

   if (ORDER < 2 || TAP < 1 || TAP >= ORDER) begin : g_param_chk
      $error("ltpg_prbs_word: TAP must lie in 1..ORDER-1");
   end

   logic [ORDER-1:0] st_q;
   logic [ORDER-1:0] walk;
   logic             fb;

   // Unroll W single-bit LFSR steps starting from the seed or the held state.
   always_comb begin
      walk = restart ? '1 : st_q;
      word = '0;
      fb   = 1'b0;
      for (int i = 0; i < W; i++) begin
         fb      = walk[ORDER-1] ^ walk[TAP-1];
         word[i] = fb;
         walk    = {walk[ORDER-2:0], fb};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '1;
      end else if (advance) begin
         st_q <= walk;
      end else if (restart) begin
         st_q <= '1;
      end
   end

   // R3
   prbs_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (st_q != '0));

endmodule

// File: rtl/ltpg_fixed_word.sv
module ltpg_fixed_word #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         advance,
   output logic [W-1:0] low_word,
   output logic [W-1:0] high_word
);

   localparam int LF_PERIOD = 10;
   localparam int LF_HALF   = LF_PERIOD / 2;
   localparam int LF_STEP   = W % LF_PERIOD;
   localparam logic HF_STEP = 1'(W % 2);

   logic [3:0] lf_q, lf_cur, lf_nxt;
   logic       hf_q, hf_cur, hf_nxt;

   always_comb begin
      lf_cur = restart ? 4'd0 : lf_q;
      hf_cur = restart ? 1'b0 : hf_q;
      for (int i = 0; i < W; i++) begin
         low_word[i]  = ((int'(lf_cur) + i) % LF_PERIOD) < LF_HALF;
         high_word[i] = ((int'(hf_cur) + i) % 2) == 0;
      end
      lf_nxt = 4'((int'(lf_cur) + LF_STEP) % LF_PERIOD);
      hf_nxt = hf_cur ^ HF_STEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lf_q <= 4'd0;
         hf_q <= 1'b0;
      end else if (advance) begin
         lf_q <= lf_nxt;
         hf_q <= hf_nxt;
      end else if (restart) begin
         lf_q <= 4'd0;
         hf_q <= 1'b0;
      end
   end

   // R4
   lf_phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (lf_q < 4'(LF_PERIOD)));

endmodule

// File: rtl/ltpg_ctrl.sv
module ltpg_ctrl
   import ltpg_pkg::*;
#(
   parameter int BEAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic              pre_en,
   input  logic [BEAT_W-1:0] pre_beats,
   input  logic              inject,
   output logic              restart,
   output logic              advance,
   output ltpg_emit_e        emit,
   output logic              flip
);

   ltpg_state_e       state_q, state_d;
   logic [BEAT_W-1:0] cnt_q, cnt_d;
   logic              go, pre_on;

   assign go     = start && !stop;
   assign pre_on = pre_en && (pre_beats != '0);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      restart = 1'b0;
      advance = 1'b0;
      emit    = EM_NONE;
      flip    = 1'b0;
      if (stop) begin
         state_d = ST_IDLE;
      end else if (go) begin
         restart = 1'b1;
         if (pre_on) begin
            state_d = ST_PRE;
            cnt_d   = pre_beats - 1'b1;
            emit    = EM_PRE;
         end else begin
            state_d = ST_PATT;
            advance = 1'b1;
            emit    = EM_PATT;
         end
      end else begin
         case (state_q)
            ST_PRE: begin
               if (cnt_q == '0) begin
                  state_d = ST_PATT;
                  advance = 1'b1;
                  emit    = EM_PATT;
               end else begin
                  cnt_d = cnt_q - 1'b1;
                  emit  = EM_PRE;
               end
            end
            ST_PATT: begin
               advance = 1'b1;
               emit    = EM_PATT;
               flip    = inject;
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   // R2
   pre_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PRE && !stop && !start && cnt_q != '0)
      |=> (state_q == ST_PRE && cnt_q == $past(cnt_q) - 1'b1));

   // R9
   stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (state_q == ST_IDLE));

endmodule

// File: rtl/linktest_patgen.sv
module linktest_patgen
   import ltpg_pkg::*;
#(
   parameter int W      = 32,
   parameter int BEAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic [2:0]        pat_sel,
   input  logic              pre_en,
   input  logic [W-1:0]      pre_word,
   input  logic [BEAT_W-1:0] pre_beats,
   input  logic              inject_err,
   input  logic [W-1:0]      user_data,
   output logic [W-1:0]      dout,
   output logic              dout_valid
);

   if (W < 2) begin : g_w_chk
      $error("linktest_patgen: W must be at least 2");
   end
   if (BEAT_W < 1) begin : g_beat_chk
      $error("linktest_patgen: BEAT_W must be at least 1");
   end

   logic       restart, advance, flip;
   ltpg_emit_e emit;
   logic [W-1:0] prbs_w [NUM_PRBS];
   logic [W-1:0] low_w, high_w, patt_w, next_w;

   ltpg_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .stop      (stop),
      .pre_en    (pre_en),
      .pre_beats (pre_beats),
      .inject    (inject_err),
      .restart   (restart),
      .advance   (advance),
      .emit      (emit),
      .flip      (flip)
   );

   for (genvar k = 0; k < NUM_PRBS; k++) begin : g_prbs
      ltpg_prbs_word #(
         .W     (W),
         .ORDER (prbs_order(k)),
         .TAP   (prbs_tap(k))
      ) u_gen (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (restart),
         .advance (advance),
         .word    (prbs_w[k])
      );
   end

   ltpg_fixed_word #(.W(W)) u_fixed (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .advance   (advance),
      .low_word  (low_w),
      .high_word (high_w)
   );

   always_comb begin
      if (pat_sel < 3'(NUM_PRBS)) begin
         patt_w = prbs_w[pat_sel[1:0]];
      end else if (pat_sel == SEL_LOW) begin
         patt_w = low_w;
      end else if (pat_sel == SEL_HIGH) begin
         patt_w = high_w;
      end else begin
         patt_w = user_data;
      end
      case (emit)
         EM_PRE:  next_w = pre_word;
         EM_PATT: next_w = patt_w ^ {{(W-1){1'b0}}, flip};
         default: next_w = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout       <= '0;
         dout_valid <= 1'b0;
      end else begin
         dout       <= next_w;
         dout_valid <= (emit != EM_NONE);
      end
   end

   // R9
   stop_clears_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!dout_valid && dout == '0));

   // R2
   pre_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stop && pre_en && pre_beats != '0)
      |=> (dout_valid && dout == $past(pre_word)));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_valid |-> (dout == '0));

endmodule

// File: tb/linktest_patgen_tb.sv
module linktest_patgen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int BW = 16;
   localparam int BB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, stop = 1'b0, pre_en = 1'b0, inject_err = 1'b0;
   logic [2:0]    pat_sel = 3'd0;
   logic [BW-1:0] pre_word = '0, user_data = '0;
   logic [BB-1:0] pre_beats = '0;
   logic [BW-1:0] dout;
   logic          dout_valid;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   bit [31:0] mst [4];
   int        lpos, hpos;

   linktest_patgen #(.W(BW), .BEAT_W(BB)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .pat_sel(pat_sel),
      .pre_en(pre_en), .pre_word(pre_word), .pre_beats(pre_beats),
      .inject_err(inject_err), .user_data(user_data),
      .dout(dout), .dout_valid(dout_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic finish_up();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      finish_up();
   end

   function automatic int ord_of(input int k);
      return (k == 0) ? 7 : (k == 1) ? 15 : (k == 2) ? 23 : 31;
   endfunction
   function automatic int tap_of(input int k);
      return (k == 0) ? 6 : (k == 1) ? 14 : (k == 2) ? 18 : 28;
   endfunction

   task automatic m_reseed();
      for (int k = 0; k < 4; k++) mst[k] = (32'd1 << ord_of(k)) - 32'd1;
      lpos = 0;
      hpos = 0;
   endtask

   // Reference word for one pattern cycle; every source advances together.
   task automatic m_word(input int sel, input logic [BW-1:0] ud, output logic [BW-1:0] w);
      logic [BW-1:0] pw [4];
      logic [BW-1:0] lw, hw;
      for (int k = 0; k < 4; k++) begin
         bit [31:0] s = mst[k];
         bit [31:0] mask = (32'd1 << ord_of(k)) - 32'd1;
         for (int i = 0; i < BW; i++) begin
            bit nb = s[ord_of(k)-1] ^ s[tap_of(k)-1];
            pw[k][i] = nb;
            s = ((s << 1) | 32'(nb)) & mask;
         end
         mst[k] = s;
      end
      for (int i = 0; i < BW; i++) begin
         lw[i] = ((lpos + i) % 10) < 5;
         hw[i] = ((hpos + i) % 2) == 0;
      end
      lpos = (lpos + BW) % 10;
      hpos = (hpos + BW) % 2;
      if (sel < 4)       w = pw[sel];
      else if (sel == 4) w = lw;
      else if (sel == 5) w = hw;
      else               w = ud;
   endtask

   task automatic check(input string req, input logic [BW-1:0] ed, input logic ev);
      n_vec++;
      if (dout !== ed || dout_valid !== ev) begin
         n_bad++;
         $display("FAIL %s: dout=%h valid=%b expected dout=%h valid=%b", req, dout, dout_valid, ed, ev);
      end
   endtask

   function automatic logic [BW-1:0] ud_fn(input int n);
      return BW'(32'h9E37 * (n + 3) ^ 32'h5A1C);
   endfunction

   int ud_n = 0;

   task automatic run_case(input int sel, input bit pen, input int beats, input int nwords,
                           input int inj_at, input bit pre_inj, input bit inj_w_start,
                           input bit do_stop, input string first_tag);
      int npre;
      bit inj_pend;
      logic [BW-1:0] w;
      string tag;
      @(negedge clk);
      pat_sel   = 3'(sel);
      pre_en    = pen;
      pre_beats = BB'(beats);
      pre_word  = BW'(16'hBC5A ^ sel);
      start     = 1'b1;
      inject_err = inj_w_start;
      user_data = ud_fn(ud_n++);
      m_reseed();
      npre = (pen && beats != 0) ? beats : 0;
      for (int b = 0; b < npre; b++) begin
         @(negedge clk);
         start = 1'b0;
         inject_err = 1'b0;
         check((b == 0) ? first_tag : "R2 preamble", pre_word, 1'b1);
         inject_err = pre_inj && (b == npre - 1); // R8 on the last beat
         user_data = ud_fn(ud_n++);
      end
      inj_pend = 1'b0;
      for (int k = 0; k < nwords; k++) begin
         logic [BW-1:0] ud_used;
         @(negedge clk);
         start = 1'b0;
         inject_err = 1'b0;
         ud_used = user_data;
         m_word(sel, ud_used, w);
         if (inj_pend) w[0] = ~w[0];
         if (inj_pend)        tag = "R7 inject";
         else if (k == 0 && npre == 0) tag = first_tag;
         else if (k == 0 && pre_inj) tag = "R8 inject on last preamble beat";
         else if (sel < 4)   tag = "R3 prbs";
         else if (sel == 4)  tag = "R4 low freq";
         else if (sel == 5)  tag = "R5 high freq";
         else                tag = "R6 bypass";
         check(tag, w, 1'b1);
         inj_pend = (k == inj_at);
         inject_err = inj_pend;
         user_data = ud_fn(ud_n++);
      end
      if (do_stop) begin
         @(negedge clk);
         inject_err = 1'b0;
         stop = 1'b1;
         @(negedge clk);
         stop = 1'b0;
         check("R9 stop", '0, 1'b0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 2 + 2);
      check("R1 reset", '0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle", '0, 1'b0);

      // Sweep every source over several preamble configurations.
      for (int sel = 0; sel < 8; sel++) begin
         run_case(sel, 1'b0, 0, 6, 2, 1'b0, 1'b0, 1'b1, "R2 no preamble");
         run_case(sel, 1'b1, 0, 5, -1, 1'b0, 1'b0, 1'b1, "R2 zero beats");
         run_case(sel, 1'b1, 1, 5, 3, 1'b1, 1'b0, 1'b1, "R2 one beat");
         run_case(sel, 1'b1, 3, 7, 1, 1'b1, 1'b0, 1'b1, "R2 three beats");
         run_case(sel, 1'b0, 9, 4, -1, 1'b0, 1'b0, 1'b1, "R2 preamble disabled");
      end
      run_case(0, 1'b1, 15, 3, -1, 1'b0, 1'b0, 1'b1, "R2 max beats");
      run_case(3, 1'b0, 0, 40, 20, 1'b0, 1'b0, 1'b1, "R3 long run");

      // R8: inject while idle.
      @(negedge clk);
      inject_err = 1'b1;
      @(negedge clk);
      inject_err = 1'b0;
      check("R8 inject while idle", '0, 1'b0);

      // R9: start and stop together while idle.
      @(negedge clk);
      start = 1'b1;
      stop  = 1'b1;
      @(negedge clk);
      start = 1'b0;
      stop  = 1'b0;
      check("R9 stop beats start", '0, 1'b0);
      @(negedge clk);
      check("R9 still idle", '0, 1'b0);

      // R10: restart while running, with inject on the restart edge.
      run_case(1, 1'b0, 0, 4, -1, 1'b0, 1'b0, 1'b0, "R2 no preamble");
      run_case(1, 1'b1, 2, 4, -1, 1'b0, 1'b1, 1'b0, "R10 restart preamble");
      run_case(4, 1'b0, 0, 5, -1, 1'b0, 1'b1, 1'b0, "R10 restart with inject R8");

      // R9 / R8: inject together with stop.
      @(negedge clk);
      stop = 1'b1;
      inject_err = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      inject_err = 1'b0;
      check("R9 stop with inject", '0, 1'b0);

      finish_up();
   end

endmodule